// File: doc/BRIEF.md
# Three-Channel Input Capture Unit

This block timestamps external events. Three capture channels watch their own input pins and share one 16-bit free-running count that arrives as an input. When a channel sees the edge kind it has been told to watch for, it copies the count into its own read-only 16-bit register, raises its status flag, and asserts its interrupt request if the matching mask bit is set.

Software reaches the unit through an 8-bit register port. The port selects the edge kind for each channel, sets the masks, reads and clears the flags, and reads each captured value as a high byte and a low byte. A read of a channel's high byte holds back any capture for that channel during that bus cycle. The capture is not lost: it lands one cycle later. Software that reads the high byte and then the low byte therefore always gets two halves of the same timestamp.

Each pin passes through a two-stage synchronizer before edge detection. The capture register loads two clocks after the first clock edge that samples the new pin level.

Top module: `inputCaptureUnit`

## Requirements
- R1: After reset, every edge-select field, every mask bit, every flag and every capture register reads zero, and `irqReq` is low.
- R2: The control byte at address 0 holds channel c's 2-bit edge select in bits [2c+1:2c]. The codes are 00 = no capture, 01 = capture on rising edges only, 10 = capture on falling edges only, 11 = capture on both edges.
- R3: If the clock edge k is the first to sample a new pin level, the capture register loads at edge k+2 with the `timerCount` value present at that edge. The flag is still clear before edge k+2.
- R4: Address map: 0 holds the edge selects, 1 holds the mask (bit c), 2 holds the flags (bit c), 4+2c holds the high byte of channel c's capture and 5+2c holds its low byte. Unused bits read as zero.
- R5: The channels work independently. Qualifying edges on several pins in the same cycle capture the same count in every affected channel.
- R6: If a qualifying capture for channel c would load in a cycle that also reads 4+2c, that read returns the old high byte. The capture then loads in the next cycle, with that cycle's count.
- R7: A capture sets the channel's flag. `irqReq[c]` is high exactly while flag c and mask bit c are both set.
- R8: Writing a byte to address 2 clears each flag whose bit in the byte is 1. Flags in 0 positions stay as they were.
- R9: Writes to the capture addresses (4 to 9) leave the captured values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerCount | input | 16 | Shared free-running count |
| capPin | input | 3 | Event pins, one per channel, asynchronous |
| busAddr | input | 4 | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from `busAddr` |
| irqReq | output | 3 | Interrupt request per channel |

## Verification
The assertions assume three things about the bus: each read or write strobe covers exactly one clock cycle, the address holds steady while its strobe is high, and high-byte reads of the same channel do not continue cycle after cycle without end. If they did, a deferred capture would wait forever. The bench drives the bus only through single-cycle tasks that change signals on the falling clock edge, and it never issues two high-byte reads back to back. Pin changes are likewise made on the falling edge, one transition at a time per pin. Each transition is followed by enough idle cycles for the synchronizer and the capture to settle before the next one.

// File: rtl/capPkg.sv
package capPkg;
  parameter int NUM_CH = 3;
  parameter int CNT_W  = 16;
  parameter int BUS_W  = 8;
  parameter int ADDR_W = 4;

  localparam int SEL_W     = 2 * NUM_CH;
  localparam int ADDR_SEL  = 0;
  localparam int ADDR_MASK = 1;
  localparam int ADDR_FLAG = 2;
  localparam int ADDR_CAP0 = 4;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_RISE = 2'b01,
    SEL_FALL = 2'b10,
    SEL_ANY  = 2'b11
  } edgeSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0]      load;
    logic [NUM_CH-1:0][1:0] edgeSel;
  } capCmd_t;
endpackage

// File: rtl/capData.sv
module capData
  import capPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CNT_W-1:0]             timerCount,
  input  logic [NUM_CH-1:0]            capPin,
  input  capCmd_t                      cmd,
  output logic [NUM_CH-1:0]            edgeHit,
  output logic [NUM_CH-1:0][CNT_W-1:0] capVal
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic syncA, syncB, prevLvl;
    logic isRise, isFall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA   <= 1'b0;
        syncB   <= 1'b0;
        prevLvl <= 1'b0;
      end else begin
        syncA   <= capPin[c];
        syncB   <= syncA;
        prevLvl <= syncB;
      end
    end

    assign isRise = syncB & ~prevLvl;
    assign isFall = ~syncB & prevLvl;

    always_comb begin
      unique case (edgeSel_e'(cmd.edgeSel[c]))
        SEL_OFF:  edgeHit[c] = 1'b0;
        SEL_RISE: edgeHit[c] = isRise;
        SEL_FALL: edgeHit[c] = isFall;
        SEL_ANY:  edgeHit[c] = isRise | isFall;
        default:  edgeHit[c] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            capVal[c] <= '0;
      else if (cmd.load[c]) capVal[c] <= timerCount;
    end

    // R3: a load strobe stores the count of that cycle
    a_r3_latch_count: assert property (@(posedge clk) disable iff (!rstN)
      cmd.load[c] |=> capVal[c] == $past(timerCount));
    // R9: without a load strobe the captured value never moves
    a_r9_value_held: assert property (@(posedge clk) disable iff (!rstN)
      !cmd.load[c] |=> $stable(capVal[c]));
  end
endmodule

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [BUS_W-1:0]             busWrData,
  output logic [BUS_W-1:0]             busRdData,
  output logic [NUM_CH-1:0]            irqReq,
  input  logic [NUM_CH-1:0]            edgeHit,
  input  logic [NUM_CH-1:0][CNT_W-1:0] capVal,
  output capCmd_t                      cmd
);
  logic [NUM_CH-1:0][1:0] edgeSelReg;
  logic [NUM_CH-1:0]      maskReg, flagReg, pendReg;
  logic [NUM_CH-1:0]      hiRead, wantLoad, loadNow;
  logic [NUM_CH-1:0][BUS_W-1:0] chRdData;
  logic                   flagWr, selWr, maskWr;
  logic                   unusedWr;

  assign selWr    = busWrEn && (busAddr == ADDR_W'(ADDR_SEL));
  assign maskWr   = busWrEn && (busAddr == ADDR_W'(ADDR_MASK));
  assign flagWr   = busWrEn && (busAddr == ADDR_W'(ADDR_FLAG));
  assign unusedWr = ^busWrData;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(ADDR_CAP0 + 2 * c);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(ADDR_CAP0 + 2 * c + 1);

    assign hiRead[c]   = busRdEn && (busAddr == HI_ADDR);
    assign wantLoad[c] = edgeHit[c] | pendReg[c];
    assign loadNow[c]  = wantLoad[c] & ~hiRead[c];

    always_comb begin
      if (busAddr == HI_ADDR)      chRdData[c] = capVal[c][CNT_W-1:BUS_W];
      else if (busAddr == LO_ADDR) chRdData[c] = capVal[c][BUS_W-1:0];
      else                         chRdData[c] = '0;
    end

    // R6: a capture held back by a high-byte read lands next cycle
    a_r6_deferred: assert property (@(posedge clk) disable iff (!rstN)
      (edgeHit[c] && hiRead[c]) |=> (cmd.load[c] || hiRead[c]));
    // R7: every load raises the flag
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
      cmd.load[c] |=> flagReg[c]);
    // R8: a one in the cleared position drops the flag
    a_r8_clear_one: assert property (@(posedge clk) disable iff (!rstN)
      (flagWr && busWrData[c] && !cmd.load[c]) |=> !flagReg[c]);
    // R8: flags not addressed by a one stay set
    a_r8_keep_zero: assert property (@(posedge clk) disable iff (!rstN)
      (flagReg[c] && !(flagWr && busWrData[c])) |=> flagReg[c]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeSelReg <= '0;
      maskReg    <= '0;
      flagReg    <= '0;
      pendReg    <= '0;
    end else begin
      if (selWr)  edgeSelReg <= busWrData[SEL_W-1:0];
      if (maskWr) maskReg    <= busWrData[NUM_CH-1:0];
      flagReg <= (flagReg & ~(flagWr ? busWrData[NUM_CH-1:0] : '0)) | loadNow;
      pendReg <= wantLoad & hiRead;
    end
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_W'(ADDR_SEL):  busRdData = {{(BUS_W-SEL_W){1'b0}}, edgeSelReg};
      ADDR_W'(ADDR_MASK): busRdData = {{(BUS_W-NUM_CH){1'b0}}, maskReg};
      ADDR_W'(ADDR_FLAG): busRdData = {{(BUS_W-NUM_CH){1'b0}}, flagReg};
      default: begin
        for (int c = 0; c < NUM_CH; c++) busRdData = busRdData | chRdData[c];
      end
    endcase
  end

  assign irqReq      = flagReg & maskReg;
  assign cmd.load    = loadNow;
  assign cmd.edgeSel = edgeSelReg;
endmodule

// File: rtl/inputCaptureUnit.sv
module inputCaptureUnit
  import capPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timerCount,
  input  logic [NUM_CH-1:0] capPin,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  output logic [NUM_CH-1:0] irqReq
);
  capCmd_t                      cmd;
  logic [NUM_CH-1:0]            edgeHit;
  logic [NUM_CH-1:0][CNT_W-1:0] capVal;

  capCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqReq    (irqReq),
    .edgeHit   (edgeHit),
    .capVal    (capVal),
    .cmd       (cmd)
  );

  capData u_data (
    .clk        (clk),
    .rstN       (rstN),
    .timerCount (timerCount),
    .capPin     (capPin),
    .cmd        (cmd),
    .edgeHit    (edgeHit),
    .capVal     (capVal)
  );
endmodule

// File: tb/test_inputCaptureUnit.sv
`timescale 1ns/1ps
module test_inputCaptureUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] tc = 16'h3A5C;
  logic [2:0]  capPin = 3'b000;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [2:0]  irqReq;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;
  logic [15:0] expCap [3] = '{16'h0, 16'h0, 16'h0};

  always #2.5 clk = ~clk;
  always @(negedge clk) tc <= tc + 16'd1;

  inputCaptureUnit i_inputCaptureUnit (
    .clk(clk), .rstN(rstN), .timerCount(tc), .capPin(capPin),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqReq(irqReq)
  );

  // vector: {channel[1:0], edge select[1:0], new pin level, capture expected}
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 2'b01, 1'b1, 1'b1}, {2'd0, 2'b01, 1'b0, 1'b0},
    {2'd1, 2'b10, 1'b1, 1'b0}, {2'd1, 2'b10, 1'b0, 1'b1},
    {2'd2, 2'b11, 1'b1, 1'b1}, {2'd2, 2'b11, 1'b0, 1'b1},
    {2'd0, 2'b00, 1'b1, 1'b0}, {2'd0, 2'b00, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    #3;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #2;
    d = busRdData;
    #1;
    busRdEn = 1'b0;
  endtask

  task automatic checkCap(input string tag, input int ch);
    logic [7:0] hi, lo;
    busRead(4'(4 + 2 * ch), hi);
    busRead(4'(5 + 2 * ch), lo);
    check(tag, {hi, lo}, expCap[ch]);
  endtask

  task automatic setPin(input int ch, input logic lvl, output logic [15:0] t);
    @(negedge clk);
    capPin[ch] = lvl;
    #1;
    t = tc;
  endtask

  initial begin
    logic [7:0]  rd;
    logic [15:0] t;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      if (a == 3) continue;
      busRead(4'(a), rd);
      check("R1 reset register", {8'h0, rd}, 16'h0);
    end
    check("R1 reset irqReq", {13'h0, irqReq}, 16'h0);

    // R2 R4 vector table
    for (int i = 0; i < 8; i++) begin
      int ch = int'(VEC[i][5:4]);
      busWrite(4'd0, 8'(VEC[i][3:2] << (2 * ch)));
      busRead(4'd0, rd);
      check("R2 select readback", {8'h0, rd}, {8'h0, 8'(VEC[i][3:2] << (2 * ch))});
      busWrite(4'd2, 8'hFF);
      setPin(ch, VEC[i][1], t);
      repeat (4) @(negedge clk);
      busRead(4'd2, rd);
      check("R2 flag after edge", {8'h0, rd}, {8'h0, 8'(VEC[i][0]) << ch});
      if (VEC[i][0]) expCap[ch] = t + 16'd2;
      checkCap("R4 captured bytes", ch);
    end

    // R3 latency, channel 1 on any edge
    busWrite(4'd0, 8'h0C);
    busWrite(4'd2, 8'hFF);
    setPin(1, 1'b1, t);
    @(negedge clk);
    busRead(4'd2, rd);
    check("R3 flag before edge k+2", {8'h0, rd}, 16'h0);
    busRead(4'd2, rd);
    check("R3 flag after edge k+2", {8'h0, rd}, 16'h2);
    expCap[1] = t + 16'd2;
    checkCap("R3 captured count", 1);

    // R6 high-byte read in the capture cycle defers the load
    busWrite(4'd0, 8'h01);
    busWrite(4'd2, 8'hFF);
    setPin(0, 1'b1, t);
    @(negedge clk);
    busRead(4'd4, rd);
    check("R6 old high byte returned", {8'h0, rd}, {8'h0, expCap[0][15:8]});
    repeat (2) @(negedge clk);
    busRead(4'd2, rd);
    check("R6 deferred flag", {8'h0, rd}, 16'h1);
    expCap[0] = t + 16'd3;
    checkCap("R6 deferred count", 0);
    setPin(0, 1'b0, t);
    repeat (4) @(negedge clk);
    checkCap("R2 rise-only ignores fall", 0);

    // R5 simultaneous edges on all channels
    busWrite(4'd0, 8'h3F);
    busWrite(4'd2, 8'hFF);
    @(negedge clk);
    capPin = ~capPin;
    #1;
    t = tc;
    repeat (4) @(negedge clk);
    busRead(4'd2, rd);
    check("R5 all flags", {8'h0, rd}, 16'h7);
    for (int c = 0; c < 3; c++) begin
      expCap[c] = t + 16'd2;
      checkCap("R5 same count", c);
    end

    // R7 interrupt masking
    check("R7 no irq with mask clear", {13'h0, irqReq}, 16'h0);
    busWrite(4'd1, 8'h02);
    check("R7 irq on masked channel", {13'h0, irqReq}, 16'h2);
    busRead(4'd1, rd);
    check("R7 mask readback", {8'h0, rd}, 16'h2);
    busWrite(4'd1, 8'h07);
    check("R7 irq all", {13'h0, irqReq}, 16'h7);

    // R8 write-one-to-clear
    busWrite(4'd2, 8'h00);
    busRead(4'd2, rd);
    check("R8 zero write keeps flags", {8'h0, rd}, 16'h7);
    busWrite(4'd2, 8'h05);
    busRead(4'd2, rd);
    check("R8 partial clear", {8'h0, rd}, 16'h2);
    check("R8 irq follows clear", {13'h0, irqReq}, 16'h2);

    // R9 capture registers are read-only
    for (int a = 4; a < 10; a++) busWrite(4'(a), 8'hAA);
    for (int c = 0; c < 3; c++) checkCap("R9 write ignored", c);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule